// File: doc/BRIEF.md
# Dual-Direction Inter-Processor Mailbox

The mailbox links two processors, called side A and side B, through two independent word queues. Each queue carries data in one direction only. Side A pushes into queue A and side B pops from it. Queue B works the same way in the other direction. Each side reaches the block through a small register bus with three locations:

- a control/status register;
- a send port, which pushes a word;
- a receive port, which pops a word.

The control/status register shows the fill state of both queues that touch that side. It also holds that side's interrupt enables and master enable, gives software a way to flush its own outgoing queue, and keeps a sticky error flag.

Each side has two interrupt pulse outputs. The first fires when its outgoing queue has been drained by the other side. The second fires when a word arrives in its incoming queue. The two queues are cross-coupled: a push or pop by one processor raises the other processor's interrupt. Setting an interrupt enable fires that interrupt at once if its condition already holds. A read from an empty queue does not stall. It returns the word in the current head slot and latches the error flag.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, both queues are empty and every enable and error bit is clear. A control read returns 0x0101 on both sides, and all four interrupt outputs are low.
- R2: Each queue holds up to 16 words of 32 bits. Words are delivered in the order they were pushed, with the read pointer wrapping after slot 15.
- R3: A control read (offset 0x0) returns the following bits, with bits 31..16 reading zero.

  | Bit | Meaning |
  |-----|---------|
  | 0 | own send queue empty |
  | 1 | own send queue full, reported only when bit 0 is clear |
  | 8 | receive queue empty |
  | 9 | receive queue full, reported only when bit 8 is clear |
  | 14 | error flag |

- R4: A control write stores only these bits and discards every other written bit:
  - bit 2: send-empty interrupt enable;
  - bit 10: receive interrupt enable;
  - bit 15: queue enable.
- R5: Writing 1 to control bit 3 empties the writer's own send queue. After a flush, that queue's head slot reads as zero until the next push.
- R6: When a side is enabled, a send write (offset 0x4) to a full queue is dropped and sets that side's error flag. The queue contents stay as they were.
- R7: When a side is enabled, a receive read (offset 0x8) of an empty queue sets that side's error flag. It returns the word in the current head slot without popping.
- R8: The error flag stays set until a control write with bit 14 = 1. A control write with bit 14 = 0 leaves it set.
- R9: When a side's enable bit is clear, its receive reads return the head word without popping, its send writes are ignored, and neither sets the error flag.
- R10: A successful push raises the receiving side's receive interrupt if that side has bit 10 set.
- R11: A successful pop that leaves the queue empty raises the sending side's send-empty interrupt if that side has bit 2 set.
- R12: Writing bit 2 from 0 to 1 fires the send-empty interrupt if the own send queue is empty after the write (including a flush in the same write). Writing bit 10 from 0 to 1 fires the receive interrupt if the receive queue is not empty.
- R13: A push and a pop on the same queue in the same cycle leave its occupancy unchanged.
- R14: Each interrupt is a registered pulse. It is high in the single cycle after the access that caused it, unless a new cause occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_sel | input | 1 | Side A access strobe |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 4 | Side A register offset (0x0, 0x4, 0x8) |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid in the access cycle |
| a_irq_send_empty | output | 1 | Side A send-queue-drained pulse |
| a_irq_recv | output | 1 | Side A word-arrived pulse |
| b_sel | input | 1 | Side B access strobe |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 4 | Side B register offset |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, valid in the access cycle |
| b_irq_send_empty | output | 1 | Side B send-queue-drained pulse |
| b_irq_recv | output | 1 | Side B word-arrived pulse |

## Verification
The bench goes after these corner cases, each named with the wrong behaviour it would expose:

- **Seventeenth push.** A design that overwrote on overflow would corrupt the oldest word; one that forgot the error would leave bit 14 clear.
- **Read past empty.** A design that popped anyway would move the head pointer, so the next delivered word would come out of order.
- **Push and pop in the same cycle.** A count that took only one of the two would lose or invent a word.
- **Cross-coupled interrupts, including enable-rising firing.** Routing them to the wrong side, or gating them on the wrong side's enable, would show as a pulse on the wrong output.

A long seeded random phase then interleaves flushes, enable changes and traffic on both sides against a bench model of the two queues.

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_sel,
  input  logic          a_wr,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq_send_empty,
  output logic          a_irq_recv,
  input  logic          b_sel,
  input  logic          b_wr,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq_send_empty,
  output logic          b_irq_recv
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] OFS_CTL = AW'(0);
  localparam logic [AW-1:0] OFS_SND = AW'(4);
  localparam logic [AW-1:0] OFS_RCV = AW'(8);

  logic [DW-1:0] mem [2][DEPTH];
  logic [PW-1:0] wp [2];
  logic [PW-1:0] rp [2];
  logic [CW-1:0] cnt [2];
  logic [CW-1:0] cnt_nx [2];
  logic [DW-1:0] head [2];
  logic [DW-1:0] wd [2];
  logic [DW-1:0] rd [2];
  logic [AW-1:0] ad [2];
  logic [1:0] sel, wr;
  logic [1:0] en_se, en_rx, on, err;
  logic [1:0] wr_ctl, wr_snd, rd_rcv, rd_ctl;
  logic [1:0] push, pop, flush, err_set, err_clr;
  logic [1:0] empty, full;
  logic [1:0] se_ev, rx_ev, irq_se, irq_rx;
  logic [15:0] ctl_rd [2];

  assign sel = {b_sel, a_sel};
  assign wr  = {b_wr, a_wr};
  assign ad[0] = a_addr;
  assign ad[1] = b_addr;
  assign wd[0] = a_wdata;
  assign wd[1] = b_wdata;
  assign a_rdata = rd[0];
  assign b_rdata = rd[1];
  assign a_irq_send_empty = irq_se[0];
  assign b_irq_send_empty = irq_se[1];
  assign a_irq_recv = irq_rx[0];
  assign b_irq_recv = irq_rx[1];

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      empty[s] = (cnt[s] == '0);
      full[s]  = (cnt[s] == CW'(DEPTH));
      head[s]  = mem[s][rp[s]];
    end
    for (int s = 0; s < 2; s++) begin
      wr_ctl[s]  = sel[s] & wr[s] & (ad[s] == OFS_CTL);
      wr_snd[s]  = sel[s] & wr[s] & (ad[s] == OFS_SND);
      rd_ctl[s]  = sel[s] & ~wr[s] & (ad[s] == OFS_CTL);
      rd_rcv[s]  = sel[s] & ~wr[s] & (ad[s] == OFS_RCV);
      flush[s]   = wr_ctl[s] & wd[s][3];
      err_clr[s] = wr_ctl[s] & wd[s][14];
      push[s]    = wr_snd[s] & on[s] & ~full[s];
      pop[s]     = rd_rcv[s] & on[s] & ~empty[1-s];
      err_set[s] = (wr_snd[s] & on[s] & full[s]) | (rd_rcv[s] & on[s] & empty[1-s]);
    end
    for (int q = 0; q < 2; q++) begin
      if (flush[q]) cnt_nx[q] = '0;
      else cnt_nx[q] = cnt[q] + CW'(push[q]) - CW'(pop[1-q]);
    end
    for (int s = 0; s < 2; s++) begin
      ctl_rd[s] = {on[s], err[s], 3'b000, en_rx[s], full[1-s] & ~empty[1-s], empty[1-s],
                   5'b00000, en_se[s], full[s] & ~empty[s], empty[s]};
      if (rd_ctl[s]) rd[s] = {{(DW-16){1'b0}}, ctl_rd[s]};
      else if (rd_rcv[s]) rd[s] = head[1-s];
      else rd[s] = '0;
      se_ev[s] = (pop[1-s] & en_se[s] & (cnt_nx[s] == '0) & ~flush[s]) |
                 (wr_ctl[s] & wd[s][2] & ~en_se[s] & (flush[s] | empty[s]));
      rx_ev[s] = (push[1-s] & en_rx[s]) |
                 (wr_ctl[s] & wd[s][10] & ~en_rx[s] & ~empty[1-s]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < 2; q++) begin
        for (int i = 0; i < DEPTH; i++) mem[q][i] <= '0;
        wp[q]  <= '0;
        rp[q]  <= '0;
        cnt[q] <= '0;
      end
      en_se  <= '0;
      en_rx  <= '0;
      on     <= '0;
      err    <= '0;
      irq_se <= '0;
      irq_rx <= '0;
    end else begin
      for (int q = 0; q < 2; q++) begin
        cnt[q] <= cnt_nx[q];
        if (flush[q]) begin
          wp[q] <= '0;
          rp[q] <= '0;
          mem[q][0] <= '0;
        end else begin
          if (push[q]) begin
            mem[q][wp[q]] <= wd[q];
            wp[q] <= (wp[q] == PW'(DEPTH-1)) ? '0 : wp[q] + 1'b1;
          end
          if (pop[1-q]) rp[q] <= (rp[q] == PW'(DEPTH-1)) ? '0 : rp[q] + 1'b1;
        end
        if (wr_ctl[q]) begin
          en_se[q] <= wd[q][2];
          en_rx[q] <= wd[q][10];
          on[q]    <= wd[q][15];
        end
        err[q] <= err_set[q] | (err[q] & ~err_clr[q]);
      end
      irq_se <= se_ev;
      irq_rx <= rx_ev;
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_chk
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[s] <= CW'(DEPTH)) else $error("count overflow"); // R2
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_snd[s] & on[s] & full[s] & ~pop[1-s]) |=> (full[s] && err[s])) else $error("full push"); // R6
    AST_UNDERFLOW_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_rcv[s] & on[s] & empty[1-s] & ~push[1-s]) |=> (err[s] && empty[1-s])) else $error("underflow"); // R7
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctl[s] & wd[s][3]) |=> empty[s]) else $error("flush"); // R5
    AST_OFF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_snd[s] & ~on[s] & ~pop[1-s]) |=> $stable(cnt[s])) else $error("disabled push"); // R9
    AST_BOTH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (push[s] & pop[1-s]) |=> $stable(cnt[s])) else $error("push+pop"); // R13
    AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (push[1-s] & en_rx[s]) |=> irq_rx[s]) else $error("rx irq"); // R10
  end
endmodule

// File: tb/sim_ipc_mailbox.sv
module sim_ipc_mailbox;
  localparam int CLK_PERIOD = 10;
  localparam int K_IDLE = 0, K_CW = 1, K_SND = 2, K_RCV = 3, K_CR = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a_sel, a_wr, b_sel, b_wr;
  logic [3:0] a_addr, b_addr;
  logic [31:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_irq_send_empty, a_irq_recv, b_irq_send_empty, b_irq_recv;
  int errors = 0, checks = 0;
  bit done = 0;

  bit [31:0] mq [2][16];
  int mw [2], mr [2], mc [2];
  bit men_se [2], men_rx [2], mon [2], merr [2];
  bit xse [2], xrx [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_mailbox u0 (.clk(clk), .rst_n(rst_n),
    .a_sel(a_sel), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .a_irq_send_empty(a_irq_send_empty), .a_irq_recv(a_irq_recv),
    .b_sel(b_sel), .b_wr(b_wr), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata),
    .b_irq_send_empty(b_irq_send_empty), .b_irq_recv(b_irq_recv));

  function automatic bit [31:0] exp_ctl(int s);
    int o = 1 - s;
    bit se = (mc[s] == 0), sf = (mc[s] == 16) && !se;
    bit re = (mc[o] == 0), rf = (mc[o] == 16) && !re;
    return {16'h0, mon[s], merr[s], 3'b0, men_rx[s], rf, re, 5'b0, men_se[s], sf, se};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(int s, int k, logic [31:0] d);
    logic sl, w; logic [3:0] a;
    sl = (k != K_IDLE); w = (k == K_CW || k == K_SND);
    a = (k == K_SND) ? 4'h4 : (k == K_RCV) ? 4'h8 : 4'h0;
    if (s == 0) begin a_sel = sl; a_wr = w; a_addr = a; a_wdata = d; end
    else begin b_sel = sl; b_wr = w; b_addr = a; b_wdata = d; end
  endtask

  task automatic step(int k0, logic [31:0] d0, int k1, logic [31:0] d1, string tag);
    int k [2]; bit [31:0] d [2];
    bit psh [2], pp [2], fl [2], es [2];
    k[0] = k0; k[1] = k1; d[0] = d0; d[1] = d1;
    @(negedge clk);
    drive(0, k0, d0); drive(1, k1, d1);
    #1;
    for (int s = 0; s < 2; s++) begin
      logic [31:0] act = (s == 0) ? a_rdata : b_rdata;
      if (k[s] == K_CR) chk({tag, " R3 ctl"}, act, exp_ctl(s));
      if (k[s] == K_RCV) chk({tag, " R2 rcv"}, act, mq[1-s][mr[1-s]]);
    end
    for (int s = 0; s < 2; s++) begin
      fl[s]  = (k[s] == K_CW) && d[s][3];
      psh[s] = (k[s] == K_SND) && mon[s] && mc[s] < 16;
      pp[s]  = (k[s] == K_RCV) && mon[s] && mc[1-s] > 0;
      es[s]  = mon[s] && (((k[s] == K_SND) && mc[s] == 16) || ((k[s] == K_RCV) && mc[1-s] == 0));
    end
    for (int s = 0; s < 2; s++) begin
      int o = 1 - s;
      int nc = fl[s] ? 0 : mc[s] + int'(psh[s]) - int'(pp[o]);
      xse[s] = (pp[o] && men_se[s] && nc == 0 && !fl[s]) ||
               (k[s] == K_CW && d[s][2] && !men_se[s] && (fl[s] || mc[s] == 0));
      xrx[s] = (psh[o] && men_rx[s]) ||
               (k[s] == K_CW && d[s][10] && !men_rx[s] && mc[o] != 0);
    end
    for (int q = 0; q < 2; q++) begin
      if (fl[q]) begin mw[q] = 0; mr[q] = 0; mc[q] = 0; mq[q][0] = 0; end
      else begin
        if (psh[q]) begin mq[q][mw[q]] = d[q]; mw[q] = (mw[q] + 1) % 16; end
        if (pp[1-q]) mr[q] = (mr[q] + 1) % 16;
        mc[q] = mc[q] + int'(psh[q]) - int'(pp[1-q]);
      end
    end
    for (int s = 0; s < 2; s++) begin
      if (k[s] == K_CW) begin
        men_se[s] = d[s][2]; men_rx[s] = d[s][10]; mon[s] = d[s][15];
        if (d[s][14]) merr[s] = 0;
      end
      if (es[s]) merr[s] = 1;
    end
    @(posedge clk); #1;
    chk({tag, " R14 a_se"}, a_irq_send_empty, xse[0]);
    chk({tag, " R14 a_rx"}, a_irq_recv, xrx[0]);
    chk({tag, " R14 b_se"}, b_irq_send_empty, xse[1]);
    chk({tag, " R14 b_rx"}, b_irq_recv, xrx[1]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    drive(0, K_IDLE, 0); drive(1, K_IDLE, 0);
    for (int q = 0; q < 2; q++) begin
      mw[q] = 0; mr[q] = 0; mc[q] = 0;
      men_se[q] = 0; men_rx[q] = 0; mon[q] = 0; merr[q] = 0;
      for (int i = 0; i < 16; i++) mq[q][i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(K_CR, 0, K_CR, 0, "R1 reset");
    chk("R1 ctl value", exp_ctl(0), 32'h0101);
    // R9 disabled: pushes ignored, reads don't pop or error
    step(K_RCV, 0, K_SND, 32'hDEAD0001, "R9");
    step(K_CR, 0, K_CR, 0, "R9");
    // R4 mask and R12 send-empty on enable rising
    step(K_CW, 32'hFFFF_FFFF, K_CW, 32'h0000_8400, "R4 R12");
    step(K_CR, 0, K_CR, 0, "R4");
    chk("R4 masked", exp_ctl(0), 32'h8505);
    // R10 and R6: fill queue A, then overflow
    for (int i = 0; i < 16; i++) step(K_SND, 32'hA000_0000 + i, K_IDLE, 0, "R10 fill");
    step(K_SND, 32'hBAD0_0000, K_CR, 0, "R6 overflow");
    step(K_CR, 0, K_IDLE, 0, "R6");
    chk("R6 full+err", exp_ctl(0), 32'hC506);
    // R2 and R11: drain with wrap, then R7 underflow
    for (int i = 0; i < 16; i++) step(K_IDLE, 0, K_RCV, 0, "R11 drain");
    step(K_IDLE, 0, K_RCV, 0, "R7 underflow");
    step(K_IDLE, 0, K_CR, 0, "R7");
    // R8 error clear rules
    step(K_IDLE, 0, K_CW, 32'h0000_8400, "R8 keep");
    step(K_IDLE, 0, K_CR, 0, "R8 keep");
    step(K_IDLE, 0, K_CW, 32'h0000_C400, "R8 clear");
    step(K_IDLE, 0, K_CR, 0, "R8 clear");
    // R13 simultaneous push and pop
    step(K_SND, 32'h1111_1111, K_IDLE, 0, "R13");
    step(K_SND, 32'h2222_2222, K_RCV, 0, "R13");
    step(K_CR, 0, K_RCV, 0, "R13");
    step(K_IDLE, 0, K_CR, 0, "R13");
    // R5 flush
    for (int i = 0; i < 3; i++) step(K_SND, 32'h5500_0000 + i, K_IDLE, 0, "R5 load");
    step(K_CW, 32'h0000_840C, K_CR, 0, "R5 flush");
    step(K_CR, 0, K_RCV, 0, "R5 head zero");
    // R12 receive enable rising with data waiting
    step(K_IDLE, 0, K_CW, 32'h0000_8000, "R12");
    step(K_SND, 32'h7777_0001, K_IDLE, 0, "R12");
    step(K_IDLE, 0, K_CW, 32'h0000_8404, "R12 rx rise");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      int k [2]; logic [31:0] d [2];
      for (int s = 0; s < 2; s++) begin
        int r = $urandom % 100;
        k[s] = (r < 34) ? K_SND : (r < 66) ? K_RCV : (r < 78) ? K_CR : (r < 83) ? K_CW : K_IDLE;
        d[s] = $urandom;
        if (k[s] == K_CW)
          d[s] = ($urandom & 32'h4404) | ((($urandom % 8) != 0) ? 32'h8000 : 0) |
                 ((($urandom % 5) == 0) ? 32'h8 : 0);
      end
      step(k[0], d[0], k[1], d[1], "RND R2");
    end
    step(K_IDLE, 0, K_IDLE, 0, "R14 quiet");
    finish_run();
  end
endmodule